// File: doc/BRIEF.md
# Page write buffer with program timer

This block sits behind the serial command decoder of a small serial memory. When a memory-write command begins, it is given a start address. It then gathers the data bytes that follow into a page buffer of four slots. Only the low two address bits advance from byte to byte, so the page base stays fixed. If more than four bytes arrive, the slot pointer wraps and the later bytes replace the earlier ones.

Nothing is programmed while bytes are streaming in. The decoder reports the rising edge of chip select, and also whether that edge fell exactly on a byte boundary. An aligned rise after at least one byte commits the buffer. Any other rise throws the buffered data away.

A commit starts a self-timed program cycle of `PROG_CYCLES` clocks, and `busy` is high for the whole of that cycle. At the start of the cycle, each loaded slot is sent to the array once as a write strobe. Slots that were never loaded are not written, so those bytes keep their old contents. A status-write session uses the same commit rule and the same timer. At the end of every cycle, a one-cycle pulse tells the decoder to clear its write-enable latch.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset `busy`, `mem_we`, `sr_we` and `wel_clr` are all low.
- R2: The first data byte of an array session goes to slot `open_addr[1:0]`. Each later byte goes to the next slot modulo 4. A strobe for slot k carries address `{open_addr[8:2], k}`, so bits [8:2] never change.
- R3: When more than four bytes are sent, a slot that is written again holds the newest byte, and that byte is the one programmed.
- R4: A `cs_rise` with `cs_aligned` high commits an open session that holds at least one byte. `busy` goes high on the next clock and stays high for exactly `PROG_CYCLES` clocks.
- R5: Counting the first busy cycle as cycle 0, slot k is strobed (`mem_we` high) in busy cycle k if and only if it was loaded in this session. No other cycle strobes.
- R6: A `cs_rise` with `cs_aligned` low closes the session. It starts no cycle and produces no strobe.
- R7: A `cs_rise` on a session that received no data byte starts no cycle.
- R8: A status session (`open_status` high) that commits pulses `sr_we` in busy cycle 0 and never raises `mem_we`. The value `sr_bp` is bits [3:2] of the last status byte received.
- R9: `wel_clr` is high for exactly one clock, in the last busy cycle (cycle `PROG_CYCLES-1`), and only after a commit.
- R10: While `busy` is high, `open_req`, `byte_valid` and `cs_rise` are ignored. No new session is opened, and no second cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| open_req | input | 1 | Pulse: a write session begins |
| open_status | input | 1 | With open_req: session targets the status byte instead of the array |
| open_addr | input | 9 | Start address of an array session |
| byte_valid | input | 1 | Pulse: one complete data byte received |
| byte_data | input | 8 | The received byte |
| cs_rise | input | 1 | Pulse: chip select went high |
| cs_aligned | input | 1 | With cs_rise: the rise came right after the last bit of a byte |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |
| sr_we | output | 1 | Status protect-bits write strobe |
| sr_bp | output | 2 | Protect bits to store |
| busy | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |

## Verification
Array sessions are tried with one byte at each of the four start offsets. Those runs show that the slot pointer starts at the address's low bits and that unloaded slots are skipped. Sessions of five and six bytes force the pointer to wrap. They separate a design that keeps the newest byte per slot from one that keeps the first, and one that lets the carry into bits [8:2] from one that does not. The bench also sends misaligned rises, rises with no data, status sessions and requests made during busy. Each of these must differ from a clean commit, by showing no busy, no strobe, or only the status strobe. Random sessions then combine lengths, offsets and alignment.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic {
    MODE_ARRAY  = 1'b0,
    MODE_STATUS = 1'b1
  } pwb_mode_e;

  // Position of the two protect bits inside a status byte.
  localparam int unsigned PROT_LSB = 2;

  // Next slot inside a page: only the offset advances, modulo the page size.
  function automatic int unsigned page_step(int unsigned off, int unsigned page_bytes);
    return (off + 1) % page_bytes;
  endfunction

  // Extracts the protect field from a status byte.
  function automatic logic [1:0] protect_bits(logic [7:0] sr_byte);
    return sr_byte[PROT_LSB +: 2];
  endfunction

endpackage

// File: rtl/pwb_slot_buf.sv
module pwb_slot_buf #(
  parameter int unsigned PAGE_BYTES = 4,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clr,
  input  logic                                 wr_en,
  input  logic [OFF_W-1:0]                     wr_off,
  input  logic [DATA_W-1:0]                    wr_data,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]    slot_data,
  output logic [PAGE_BYTES-1:0]                slot_mask
);

  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_off == OFF_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_data[k] <= '0;
        slot_mask[k] <= 1'b0;
      end else if (clr) begin
        slot_mask[k] <= 1'b0;
      end else if (sel) begin
        slot_data[k] <= wr_data;
        slot_mask[k] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwb_session_ctl.sv
module pwb_session_ctl
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PAGE_BYTES = 4,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
  localparam int unsigned BASE_W    = ADDR_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busy,
  input  logic                  open_req,
  input  logic                  open_status,
  input  logic [ADDR_W-1:0]     open_addr,
  input  logic                  byte_valid,
  input  logic [DATA_W-1:0]     byte_data,
  input  logic                  cs_rise,
  input  logic                  cs_aligned,
  input  logic [PAGE_BYTES-1:0] slot_mask,
  output pwb_mode_e             mode,
  output logic [BASE_W-1:0]     page_base,
  output logic [OFF_W-1:0]      wr_off,
  output logic                  buf_clr,
  output logic                  buf_wr,
  output logic [1:0]            sr_bp_hold,
  output logic                  commit_evt,
  output logic                  discard_evt
);

  logic       open_q;
  logic       sr_got_q;
  logic       idle;
  logic       take_open;
  logic       take_byte;
  logic       has_data;

  assign idle      = !busy;
  assign take_open = idle && !cs_rise && open_req;
  assign take_byte = idle && !cs_rise && !open_req && byte_valid && open_q;
  assign has_data  = (mode == MODE_ARRAY) ? (|slot_mask) : sr_got_q;

  assign commit_evt  = idle && cs_rise && open_q && cs_aligned && has_data;
  assign discard_evt = idle && cs_rise && open_q && !commit_evt;

  assign buf_clr = take_open;
  assign buf_wr  = take_byte && (mode == MODE_ARRAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      mode       <= MODE_ARRAY;
      page_base  <= '0;
      wr_off     <= '0;
      sr_bp_hold <= '0;
      sr_got_q   <= 1'b0;
    end else if (idle) begin
      if (cs_rise) begin
        open_q <= 1'b0;
      end else if (open_req) begin
        open_q    <= 1'b1;
        mode      <= open_status ? MODE_STATUS : MODE_ARRAY;
        page_base <= open_addr[ADDR_W-1:OFF_W];
        wr_off    <= open_addr[OFF_W-1:0];
        sr_got_q  <= 1'b0;
      end else if (take_byte) begin
        if (mode == MODE_ARRAY) begin
          wr_off <= OFF_W'(page_step(32'(wr_off), PAGE_BYTES));
        end else begin
          sr_bp_hold <= protect_bits(byte_data[7:0]);
          sr_got_q   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
  parameter int unsigned PROG_CYCLES = 12,
  localparam int unsigned CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] phase,
  output logic             last
);

  assign last = busy && (phase == CNT_W'(PROG_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        phase <= '0;
      end
    end else if (last) begin
      busy <= 1'b0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/pwb_strobe_gen.sv
module pwb_strobe_gen
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PAGE_BYTES = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CNT_W      = 4,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
  localparam int unsigned BASE_W    = ADDR_W - OFF_W
) (
  input  logic                              busy,
  input  logic [CNT_W-1:0]                  phase,
  input  pwb_mode_e                         mode,
  input  logic [BASE_W-1:0]                 page_base,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] slot_data,
  input  logic [PAGE_BYTES-1:0]             slot_mask,
  input  logic [1:0]                        sr_bp_hold,
  output logic                              mem_we,
  output logic [ADDR_W-1:0]                 mem_addr,
  output logic [DATA_W-1:0]                 mem_wdata,
  output logic                              sr_we,
  output logic [1:0]                        sr_bp
);

  logic [PAGE_BYTES-1:0] hit;
  logic [OFF_W-1:0]      slot;

  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_hit
    assign hit[k] = busy && (mode == MODE_ARRAY) && slot_mask[k] &&
                    (phase == CNT_W'(k));
  end

  always_comb begin
    mem_wdata = '0;
    slot      = '0;
    for (int k = 0; k < PAGE_BYTES; k++) begin
      if (hit[k]) begin
        mem_wdata = mem_wdata | slot_data[k];
        slot      = slot | OFF_W'(k);
      end
    end
  end

  assign mem_we   = |hit;
  assign mem_addr = {page_base, slot};
  assign sr_we    = busy && (mode == MODE_STATUS) && (phase == '0);
  assign sr_bp    = sr_bp_hold;

endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PAGE_BYTES  = 4,
  parameter int unsigned PROG_CYCLES = 12,
  localparam int unsigned OFF_W      = $clog2(PAGE_BYTES),
  localparam int unsigned BASE_W     = ADDR_W - OFF_W,
  localparam int unsigned CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_req,
  input  logic              open_status,
  input  logic [ADDR_W-1:0] open_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sr_we,
  output logic [1:0]        sr_bp,
  output logic              busy,
  output logic              wel_clr
);

  pwb_mode_e                         mode;
  logic [BASE_W-1:0]                 page_base;
  logic [OFF_W-1:0]                  wr_off;
  logic                              buf_clr;
  logic                              buf_wr;
  logic [1:0]                        sr_bp_hold;
  logic                              commit_evt;
  logic                              discard_evt;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] slot_data;
  logic [PAGE_BYTES-1:0]             slot_mask;
  logic [CNT_W-1:0]                  phase;
  logic                              last;

  pwb_session_ctl #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .open_req(open_req), .open_status(open_status), .open_addr(open_addr),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .cs_rise(cs_rise), .cs_aligned(cs_aligned), .slot_mask(slot_mask),
    .mode(mode), .page_base(page_base), .wr_off(wr_off),
    .buf_clr(buf_clr), .buf_wr(buf_wr), .sr_bp_hold(sr_bp_hold),
    .commit_evt(commit_evt), .discard_evt(discard_evt)
  );

  pwb_slot_buf #(
    .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
    .wr_off(wr_off), .wr_data(byte_data),
    .slot_data(slot_data), .slot_mask(slot_mask)
  );

  pwb_prog_timer #(
    .PROG_CYCLES(PROG_CYCLES)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(commit_evt),
    .busy(busy), .phase(phase), .last(last)
  );

  pwb_strobe_gen #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_stb (
    .busy(busy), .phase(phase), .mode(mode), .page_base(page_base),
    .slot_data(slot_data), .slot_mask(slot_mask), .sr_bp_hold(sr_bp_hold),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sr_we(sr_we), .sr_bp(sr_bp)
  );

  assign wel_clr = last;

endmodule

// File: rtl/pwb_page_writer_chk.sv
module pwb_page_writer_chk #(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned OFF_W       = 2,
  parameter int unsigned PROG_CYCLES = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_rise,
  input logic                cs_aligned,
  input logic                busy,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                sr_we,
  input logic                wel_clr,
  input logic [ADDR_W-OFF_W-1:0] page_base,
  input logic                commit_evt,
  input logic                discard_evt
);

  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else        run_len <= busy ? run_len + 1 : 0;
  end

  AST_PAGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[ADDR_W-1:OFF_W] == page_base); // R2
  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> busy); // R4
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && cs_aligned)); // R4
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == PROG_CYCLES); // R4
  AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R5
  AST_DISCARD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    discard_evt |=> !busy); // R6
  AST_SR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we |-> (busy && !mem_we)); // R8
  AST_WEL_END: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy); // R9
  AST_WEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wel_clr) |=> busy); // R10

endmodule

bind pwb_page_writer pwb_page_writer_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
  .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .sr_we(sr_we),
  .wel_clr(wel_clr), .page_base(page_base), .commit_evt(commit_evt),
  .discard_evt(discard_evt)
);

// File: tb/pwb_page_writer_tb.sv
`timescale 1ns/1ps
module pwb_page_writer_tb;

  localparam int P = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       open_req = 1'b0, open_status = 1'b0;
  logic [8:0] open_addr = '0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       cs_rise = 1'b0, cs_aligned = 1'b0;
  logic       mem_we, sr_we, busy, wel_clr;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [1:0] sr_bp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwb_page_writer #(.PROG_CYCLES(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .open_req(open_req), .open_status(open_status),
    .open_addr(open_addr), .byte_valid(byte_valid), .byte_data(byte_data),
    .cs_rise(cs_rise), .cs_aligned(cs_aligned), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sr_we(sr_we), .sr_bp(sr_bp),
    .busy(busy), .wel_clr(wel_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Slot that byte i of a session lands in: low two address bits plus i, mod 4.
  function automatic int slot_of(input logic [8:0] a, input int i);
    return (int'(a[1:0]) + i) & 3;
  endfunction

  task automatic run_txn(input bit status, input logic [8:0] a, input int n,
                         input bit aligned, input bit poke);
    logic [7:0] d;
    logic [7:0] ed[4];
    bit         ev[4];
    bit         seen[4];
    logic [1:0] ebp = '0;
    bit         commit;
    int         busy_cnt = 0, wel_cnt = 0, wel_at = -1, sr_cnt = 0, sr_at = -1;
    for (int k = 0; k < 4; k++) begin ev[k] = 0; seen[k] = 0; ed[k] = '0; end
    @(negedge clk);
    open_req = 1'b1; open_status = status; open_addr = a;
    @(negedge clk);
    open_req = 1'b0;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      if (status) ebp = d[3:2];
      else begin ed[slot_of(a, i)] = d; ev[slot_of(a, i)] = 1; end
      byte_valid = 1'b1; byte_data = d;
      @(negedge clk);
    end
    byte_valid = 1'b0;
    cs_rise = 1'b1; cs_aligned = aligned;
    @(negedge clk);
    cs_rise = 1'b0; cs_aligned = 1'b0;
    commit = aligned && (n > 0);
    for (int c = 0; c < P + 3; c++) begin
      if (busy) busy_cnt++;
      if (mem_we) begin
        chk(c < 4 && !status && ev[c], "R5 strobe cycle", c, -1);
        if (c < 4) begin
          seen[c] = 1;
          chk(mem_addr == {a[8:2], 2'(c)}, "R2 address", int'(mem_addr), int'({a[8:2], 2'(c)}));
          chk(mem_wdata == ed[c], "R3 data", int'(mem_wdata), int'(ed[c]));
        end
      end
      if (sr_we) begin sr_cnt++; sr_at = c;
        chk(sr_bp == ebp, "R8 protect bits", int'(sr_bp), int'(ebp)); end
      if (wel_clr) begin wel_cnt++; wel_at = c; end
      if (poke) begin
        open_req = (c == 5); open_status = 1'b0; open_addr = 9'h1ff;
        byte_valid = (c == 6); byte_data = 8'h5a;
        cs_rise = (c == 7); cs_aligned = (c == 7);
      end
      @(negedge clk);
    end
    open_req = 1'b0; byte_valid = 1'b0; cs_rise = 1'b0; cs_aligned = 1'b0;
    chk(busy_cnt == (commit ? P : 0), commit ? "R4 busy length" :
        (aligned ? "R7 no data no cycle" : "R6 misaligned no cycle"), busy_cnt, commit ? P : 0);
    for (int k = 0; k < 4; k++)
      chk(seen[k] == (commit && !status && ev[k]), "R5 slot strobed", seen[k], commit && !status && ev[k]);
    chk(sr_cnt == ((commit && status) ? 1 : 0) && (sr_cnt == 0 || sr_at == 0),
        "R8 status strobe", sr_cnt, (commit && status) ? 1 : 0);
    chk(wel_cnt == (commit ? 1 : 0) && (wel_cnt == 0 || wel_at == P - 1),
        "R9 wel pulse cycle", wel_at, commit ? P - 1 : -1);
    if (poke) begin
      // R10: the request made during busy opened nothing, so this rise commits nothing.
      cs_rise = 1'b1; cs_aligned = 1'b1;
      @(negedge clk);
      cs_rise = 1'b0; cs_aligned = 1'b0;
      for (int c = 0; c < 3; c++) begin
        chk(!busy && !mem_we, "R10 ignored while busy", busy, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk(!busy && !mem_we && !sr_we && !wel_clr, "R1 reset outputs", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_we && !sr_we && !wel_clr, "R1 idle after reset", busy, 0);
    for (int o = 0; o < 4; o++) run_txn(0, 9'h0a4 + 9'(o), 1, 1, 0); // R2 each offset
    run_txn(0, 9'h1fe, 6, 1, 0);   // R3 wrap, page must not carry into bits [8:2]
    run_txn(0, 9'h033, 5, 1, 0);   // R3
    run_txn(0, 9'h100, 3, 0, 0);   // R6
    run_txn(0, 9'h100, 0, 1, 0);   // R7
    run_txn(1, 9'h000, 1, 1, 0);   // R8
    run_txn(1, 9'h000, 2, 0, 0);   // R6 status path
    run_txn(0, 9'h07d, 2, 1, 1);   // R10
    for (int t = 0; t < 40; t++)
      run_txn(($urandom % 5) == 0, 9'($urandom), $urandom % 7, ($urandom % 4) != 0, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule